// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block runs the complete erase procedure for a byte-wide flash array split into equal-sized blocks. Software or a host state machine presents a mask of blocks to erase and pulses `start`. If the prewrite phase is enabled, the sequencer first programs every byte of the selected blocks to zero. It then repeats a cycle of erase pulse and verify pass until every selected block reads back erased, or until the retry budget runs out.

During each erase pulse `erase_en` and `wdt_en` are high, and `erase_sel` tells the array which blocks to erase. The first pulse lasts `P0_CYC` cycles. The width doubles after each of the first `DOUBLINGS` pulses and then stays fixed. The verify pass walks each still-selected block from its lowest address. It raises `verify_en`, waits a set-up time, dummy-writes 0xFF to latch the address, waits a hold time and reads the byte back. A block whose bytes all read 0xFF is removed from the mask, so later pulses touch only blocks that are not yet verified. All waits are counted in clock cycles set by parameters.

The flash port is a fixed-timing synchronous memory port. A read issued in one cycle returns its data on `flash_rdata` in the next cycle. The array cannot stall, so this port has no valid/ready handshake and no back-pressure. `start`, `busy`, `done` and `error` are plain level control and status pins.

Top module: `flash_erase_seq`

## Requirements
- R1: `start` is accepted only while `busy` is 0. `busy` is 1 in the cycle after an accepted start with a nonzero mask and stays 1 until the run ends. A `start` pulse while busy changes neither the mask nor the flow of the run.
- R2: With prewrite enabled, every byte of every selected block receives exactly one write of 0x00 (`flash_we`=1, `verify_en`=0) before the first erase pulse. No byte of an unselected block is written.
- R3: Erase pulse n (counting from 1) holds `erase_en` high for P0_CYC·2^(min(n, DOUBLINGS+1)−1) consecutive cycles. `wdt_en` equals `erase_en` in every cycle.
- R4: Each erase pulse is followed directly by a verify pass. For each block, `verify_en` is high for TVS1_CYC cycles before the first dummy write. The dummy write drives data 0xFF. The read pulse (`flash_re`) comes TVS2_CYC+1 cycles after each dummy write.
- R5: A byte passes only if it reads 0xFF. On a mismatch `verify_en` drops in that cycle and a new erase pulse starts with the retry count raised by 1. The run uses exactly as many pulses as its slowest-to-erase selected block needs.
- R6: Blocks are verified from lowest to highest index. A block that fully passes is cleared from `erase_sel` and verify moves to the next higher selected block. `erase_sel` never gains a bit during a run.
- R7: When the mask becomes empty the run ends with `done`=1. `done` stays 1 until the next accepted start, which clears it. A start with an all-zero mask sets `done` on the next cycle and issues no pulse.
- R8: If verify fails after pulse MAX_TRY, the run ends with `error`=1 and `done`=0, after exactly MAX_TRY pulses. `error` stays 1 until the next accepted start clears it.
- R9: No prewrite (zero-data) write occurs once the first erase pulse of a run has started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with `block_mask` (used only when idle) |
| block_mask | input | NBLK | Blocks to erase, bit i = block i |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky: last run erased all selected blocks |
| error | output | 1 | Sticky: last run hit the retry limit |
| erase_en | output | 1 | Erase pulse strobe to the array |
| verify_en | output | 1 | Erase-verify mode strobe to the array |
| wdt_en | output | 1 | Watchdog enable, high only during a pulse |
| erase_sel | output | NBLK | Blocks still to be erased |
| flash_addr | output | AW | Byte address to the array |
| flash_wdata | output | 8 | Write data (0x00 prewrite, 0xFF dummy write) |
| flash_we | output | 1 | Write strobe |
| flash_re | output | 1 | Read strobe; data valid on the next cycle |
| flash_rdata | input | 8 | Read data from the array |

## Verification
A start driven before one edge shows as `busy` or `done` at the following sample. The bench checks this one cycle after the start pulse. Pulse widths, set-up cycles and the read-after-write distance are measured with a running cycle count sampled on falling edges. Each is compared when its strobe ends or its read fires. Pulse counts, per-pulse `erase_sel` and the final `done`/`error` state are predicted from the per-block erase thresholds that the bench flash model uses. These results are checked once `busy` falls.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PREW, ST_PULSE, ST_VSET, ST_VLAT, ST_VHOLD, ST_VREAD, ST_VCHK
  } seq_state_e;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  localparam logic [7:0] PROG_BYTE   = 8'h00;
endpackage

// File: rtl/fes_pick.sv
module fes_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/fes_countdown.sv
module fes_countdown #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= val - CW'(1);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end
  assign expired = (cnt == '0);

  // R3
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (val != '0));
  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/fes_width_gen.sv
module fes_width_gen #(
  parameter int P0        = 16,
  parameter int DOUBLINGS = 4,
  parameter int WW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          grow,
  output logic [WW-1:0] width,
  output logic [WW-1:0] width_nx
);
  localparam int SW = $clog2(DOUBLINGS + 1);
  localparam logic [WW-1:0] WMAX = WW'(P0 << DOUBLINGS);
  logic [SW-1:0] steps;

  assign width_nx = (int'(steps) < DOUBLINGS) ? (width << 1) : width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width <= WW'(P0);
      steps <= '0;
    end else if (restart) begin
      width <= WW'(P0);
      steps <= '0;
    end else if (grow && int'(steps) < DOUBLINGS) begin
      width <= width_nx;
      steps <= steps + SW'(1);
    end
  end

  // R3
  width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    width <= WMAX);
  // R3
  grow_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grow && !restart && int'(steps) < DOUBLINGS) |=> (width == ($past(width) << 1)));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int NBLK      = 8,
  parameter int BLK_BYTES = 16,
  parameter int P0_CYC    = 1024,
  parameter int DOUBLINGS = 4,
  parameter int TVS1_CYC  = 8,
  parameter int TVS2_CYC  = 4,
  parameter int MAX_TRY   = 602,
  parameter bit PREWRITE  = 1'b1,
  parameter int AW        = $clog2(NBLK * BLK_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NBLK-1:0] block_mask,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic            erase_en,
  output logic            verify_en,
  output logic            wdt_en,
  output logic [NBLK-1:0] erase_sel,
  output logic [AW-1:0]   flash_addr,
  output logic [7:0]      flash_wdata,
  output logic            flash_we,
  output logic            flash_re,
  input  logic [7:0]      flash_rdata
);
  localparam int IW   = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int WMAX = P0_CYC << DOUBLINGS;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int TMX  = (TVS1_CYC > TVS2_CYC) ? TVS1_CYC : TVS2_CYC;
  localparam int CMX  = (WMAX > TMX) ? WMAX : TMX;
  localparam int CW   = $clog2(CMX + 1);
  localparam int TW   = $clog2(MAX_TRY + 1);

  seq_state_e      state;
  logic [NBLK-1:0] mask;
  logic [IW-1:0]   cur;
  logic [AW-1:0]   addr;
  logic [TW-1:0]   tries;
  logic            done_r, err_r;

  logic [NBLK-1:0] lo_vec, hi_vec, above;
  logic            lo_any, hi_any;
  logic [IW-1:0]   lo_idx, hi_idx;
  logic            cd_load, cd_done, w_grow, w_restart;
  logic [CW-1:0]   cd_val;
  logic [WW-1:0]   width, width_nx;
  logic            at_last, byte_ok, start_ok;

  function automatic logic [AW-1:0] base_of(input logic [IW-1:0] b);
    return AW'(int'(b) * BLK_BYTES);
  endfunction

  assign lo_vec  = (state == ST_IDLE) ? block_mask : mask;
  assign above   = ({NBLK{1'b1}} << cur) << 1;
  assign hi_vec  = mask & above;
  assign at_last = (addr == base_of(cur) + AW'(BLK_BYTES - 1));
  assign byte_ok = (flash_rdata == ERASED_BYTE);
  assign start_ok = (state == ST_IDLE) && start;
  assign w_restart = start_ok;

  fes_pick #(.N(NBLK), .IW(IW)) u_lo (.vec(lo_vec), .any(lo_any), .idx(lo_idx));
  fes_pick #(.N(NBLK), .IW(IW)) u_hi (.vec(hi_vec), .any(hi_any), .idx(hi_idx));

  fes_countdown #(.CW(CW)) u_cd (
    .clk(clk), .rst_n(rst_n), .load(cd_load), .val(cd_val), .expired(cd_done));

  fes_width_gen #(.P0(P0_CYC), .DOUBLINGS(DOUBLINGS), .WW(WW)) u_wg (
    .clk(clk), .rst_n(rst_n), .restart(w_restart), .grow(w_grow),
    .width(width), .width_nx(width_nx));

  // timer loads and width growth
  always_comb begin
    cd_load = 1'b0;
    cd_val  = CW'(TVS1_CYC);
    w_grow  = 1'b0;
    unique case (state)
      ST_IDLE:  if (start && lo_any && !PREWRITE) begin cd_load = 1'b1; cd_val = CW'(P0_CYC); end
      ST_PREW:  if (at_last && !hi_any) begin cd_load = 1'b1; cd_val = CW'(P0_CYC); end
      ST_PULSE: if (cd_done) cd_load = 1'b1;
      ST_VLAT:  begin cd_load = 1'b1; cd_val = CW'(TVS2_CYC); end
      ST_VCHK: begin
        if (byte_ok && at_last && hi_any) cd_load = 1'b1;
        else if (!byte_ok && int'(tries) < MAX_TRY) begin
          cd_load = 1'b1;
          cd_val  = CW'(width_nx);
          w_grow  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; mask <= '0; cur <= '0; addr <= '0;
      tries <= '0; done_r <= 1'b0; err_r <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          done_r <= !lo_any;
          err_r  <= 1'b0;
          mask   <= block_mask;
          tries  <= TW'(1);
          cur    <= lo_idx;
          addr   <= base_of(lo_idx);
          if (lo_any) state <= PREWRITE ? ST_PREW : ST_PULSE;
        end
        ST_PREW: begin
          if (!at_last) addr <= addr + AW'(1);
          else if (hi_any) begin cur <= hi_idx; addr <= base_of(hi_idx); end
          else state <= ST_PULSE;
        end
        ST_PULSE: if (cd_done) begin
          state <= ST_VSET; cur <= lo_idx; addr <= base_of(lo_idx);
        end
        ST_VSET:  if (cd_done) state <= ST_VLAT;
        ST_VLAT:  state <= ST_VHOLD;
        ST_VHOLD: if (cd_done) state <= ST_VREAD;
        ST_VREAD: state <= ST_VCHK;
        ST_VCHK: begin
          if (byte_ok) begin
            if (!at_last) begin
              addr <= addr + AW'(1); state <= ST_VLAT;
            end else begin
              mask[cur] <= 1'b0;
              if (hi_any) begin
                cur <= hi_idx; addr <= base_of(hi_idx); state <= ST_VSET;
              end else begin
                done_r <= 1'b1; state <= ST_IDLE;
              end
            end
          end else if (int'(tries) >= MAX_TRY) begin
            err_r <= 1'b1; state <= ST_IDLE;
          end else begin
            tries <= tries + TW'(1); state <= ST_PULSE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign done        = done_r;
  assign error       = err_r;
  assign erase_en    = (state == ST_PULSE);
  assign wdt_en      = (state == ST_PULSE);
  assign erase_sel   = mask;
  assign flash_addr  = addr;
  assign flash_we    = (state == ST_PREW) || (state == ST_VLAT);
  assign flash_wdata = (state == ST_VLAT) ? ERASED_BYTE : PROG_BYTE;
  assign flash_re    = (state == ST_VREAD);
  assign verify_en   = (state == ST_VSET) || (state == ST_VLAT) || (state == ST_VHOLD) ||
                       (state == ST_VREAD) || ((state == ST_VCHK) && byte_ok && !at_last);

  // R4
  pulse_then_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_en) |-> verify_en);
  // R4
  latch_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_we && verify_en) |-> (flash_wdata == ERASED_BYTE));
  // R5
  tries_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (tries == $past(tries) || tries == $past(tries) + TW'(1)));
  // R6
  mask_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((erase_sel & ~$past(erase_sel)) == '0));
  // R7
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (erase_sel == '0));
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R8
  err_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (int'(tries) == MAX_TRY && !done));
endmodule

// File: tb/sim_flash_erase_seq.sv
`timescale 1ns/1ps
module sim_flash_erase_seq;
  localparam int NB = 8, BB = 4, P0 = 4, DBL = 4, TV1 = 3, TV2 = 2, MAXT = 6;
  localparam int AW = $clog2(NB * BB);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, busy, done, error, erase_en, verify_en, wdt_en, flash_we, flash_re;
  logic [NB-1:0] block_mask, erase_sel;
  logic [AW-1:0] flash_addr;
  logic [7:0] flash_wdata, flash_rdata;

  flash_erase_seq #(.NBLK(NB), .BLK_BYTES(BB), .P0_CYC(P0), .DOUBLINGS(DBL),
    .TVS1_CYC(TV1), .TVS2_CYC(TV2), .MAX_TRY(MAXT), .PREWRITE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .block_mask(block_mask), .busy(busy),
    .done(done), .error(error), .erase_en(erase_en), .verify_en(verify_en),
    .wdt_en(wdt_en), .erase_sel(erase_sel), .flash_addr(flash_addr),
    .flash_wdata(flash_wdata), .flash_we(flash_we), .flash_re(flash_re),
    .flash_rdata(flash_rdata));

  int nchk = 0, nbad = 0;
  logic [7:0] mem [NB*BB];
  int thr [NB];
  int acc [NB];
  int kreq [NB];
  int zw [NB];
  logic [NB-1:0] cur_mask;
  int pidx, cyc, wr_t, ve_run, run_len, wdt_bad;
  bit first_wr, prev_er, prev_ve;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expw(input int n);
    int e = (n < DBL + 1) ? n : DBL + 1;
    return P0 << (e - 1);
  endfunction

  function automatic int need(input int t);
    int cum = 0;
    for (int k = 1; k <= 40; k++) begin
      cum += expw(k);
      if (cum >= t) return k;
    end
    return 1000;
  endfunction

  function automatic logic [NB-1:0] exp_sel(input int p);
    logic [NB-1:0] m = cur_mask;
    for (int r = 1; r < p; r++) begin
      for (int j = 0; j < NB; j++) begin
        if (m[j]) begin
          if (kreq[j] <= r) m[j] = 1'b0;
          else break;
        end
      end
    end
    return m;
  endfunction

  // flash array model: cumulative erase cycles per block against a threshold
  always @(posedge clk) begin
    if (flash_we && !verify_en) mem[flash_addr] = flash_wdata;
    if (flash_re) flash_rdata = mem[flash_addr];
    if (erase_en) begin
      for (int j = 0; j < NB; j++) begin
        if (erase_sel[j]) begin
          acc[j] = acc[j] + 1;
          if (acc[j] >= thr[j])
            for (int b = 0; b < BB; b++) mem[j*BB + b] = 8'hFF;
        end
      end
    end
  end

  // timing monitor
  always @(negedge clk) begin
    cyc++;
    if (wdt_en !== erase_en) wdt_bad++;
    if (erase_en && !prev_er) begin
      pidx++;
      run_len = 1;
      chk(erase_sel == exp_sel(pidx), "R6 erase_sel at pulse start", int'(erase_sel), int'(exp_sel(pidx)));
      if (pidx == 1)
        for (int j = 0; j < NB; j++)
          chk(zw[j] == (cur_mask[j] ? BB : 0), "R2 prewrite count", zw[j], cur_mask[j] ? BB : 0);
    end else if (erase_en) run_len++;
    if (!erase_en && prev_er)
      chk(run_len == expw(pidx), "R3 pulse width", run_len, expw(pidx));
    if (flash_we && !verify_en && flash_wdata == 8'h00) begin
      zw[int'(flash_addr) / BB]++;
      if (pidx > 0) chk(1'b0, "R9 zero write after pulse", pidx, 0);
    end
    if (verify_en && !prev_ve) begin ve_run = 0; first_wr = 1'b1; end
    if (verify_en && flash_we) begin
      if (first_wr) chk(ve_run == TV1, "R4 verify set-up", ve_run, TV1);
      first_wr = 1'b0;
      wr_t = cyc;
    end else if (verify_en && first_wr) ve_run++;
    if (flash_re) chk(cyc - wr_t == TV2 + 1, "R4 read after latch", cyc - wr_t, TV2 + 1);
    prev_er = erase_en;
    prev_ve = verify_en;
  end

  task automatic run_case(input logic [NB-1:0] m, input bit poke);
    int maxk = 0;
    cur_mask = m;
    for (int j = 0; j < NB; j++) begin
      acc[j] = 0; zw[j] = 0; kreq[j] = need(thr[j]);
      if (m[j] && kreq[j] > maxk) maxk = kreq[j];
    end
    for (int a = 0; a < NB*BB; a++) mem[a] = 8'($urandom % 255);
    pidx = 0;
    @(negedge clk);
    block_mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    chk(done == 1'b0 && error == 1'b0, "R7 start clears flags", {done, error}, 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      block_mask = {NB{1'b1}}; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1 && done == 1'b0, "R1 start while busy ignored", busy, 1);
    end
    while (busy) @(negedge clk);
    if (maxk > MAXT) begin
      chk(error == 1'b1 && done == 1'b0, "R8 error at limit", {done, error}, 1);
      chk(pidx == MAXT, "R8 pulse count", pidx, MAXT);
    end else begin
      chk(done == 1'b1 && error == 1'b0, "R7 done", {done, error}, 2);
      chk(pidx == maxk, "R5 pulse count", pidx, maxk);
      chk(erase_sel == '0, "R6 mask emptied", int'(erase_sel), 0);
      for (int j = 0; j < NB; j++)
        if (m[j])
          for (int b = 0; b < BB; b++)
            chk(mem[j*BB + b] == 8'hFF, "R5 block erased", mem[j*BB + b], 255);
    end
    for (int j = 0; j < NB; j++)
      if (!m[j]) chk(zw[j] == 0, "R2 unselected untouched", zw[j], 0);
    chk(wdt_bad == 0, "R3 wdt_en equals erase_en", wdt_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    cyc = 0; wdt_bad = 0; pidx = 0; wr_t = 0; ve_run = 0; run_len = 0;
    first_wr = 1'b0; prev_er = 1'b0; prev_ve = 1'b0; flash_rdata = 8'h00;
    cur_mask = '0;
    for (int j = 0; j < NB; j++) begin thr[j] = 1; acc[j] = 0; zw[j] = 0; kreq[j] = 1; end
    rst_n = 1'b0; start = 1'b0; block_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error && !erase_en && !verify_en && !flash_we && !flash_re,
        "R1 reset state", {busy, done, error, erase_en, verify_en}, 0);

    // one pulse erases all blocks
    for (int j = 0; j < NB; j++) thr[j] = 1;
    run_case(8'hFF, 1'b0);
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R7 done sticky", done, 1);

    // boundaries of cumulative pulse widths, last allowed pulse
    thr[0] = 4; thr[1] = 5; thr[2] = 188;
    run_case(8'h07, 1'b0);

    // lower block slower than higher one, with ignored start
    thr[0] = 100; thr[5] = 1;
    run_case(8'h21, 1'b1);

    // retry limit reached
    thr[0] = 1; thr[3] = 189;
    run_case(8'h09, 1'b0);
    repeat (20) @(negedge clk);
    chk(error == 1'b1 && done == 1'b0, "R8 error sticky", error, 1);

    // single top block
    thr[7] = 29;
    run_case(8'h80, 1'b0);

    // empty mask
    @(negedge clk);
    block_mask = '0; start = 1'b1; pidx = 0;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R7 empty mask done", {done, busy}, 2);
    repeat (5) @(negedge clk);
    chk(pidx == 0 && busy == 1'b0, "R7 empty mask no pulse", pidx, 0);

    // random cases
    for (int c = 0; c < 8; c++) begin
      logic [NB-1:0] m;
      m = NB'($urandom % 255 + 1);
      for (int j = 0; j < NB; j++) thr[j] = int'($urandom % 188) + 1;
      run_case(m, c[0]);
    end

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule